// File: doc/BRIEF.md
# Integer Add/Subtract/Compare Unit

This block is the arithmetic slice of a 64-bit integer execute stage. A 7-bit function code picks the operation. Operand A and operand B arrive already selected, so B may be a register value or a literal. The block returns a 64-bit result, an overflow-trap flag and an illegal-function flag. Outputs are registered and appear one clock after the inputs are sampled.

The supported operations fall into four groups:
- Add and subtract, on a 32-bit or a 64-bit operand size. Each can scale A by 4 or by 8 before the operation.
- Trapping add and subtract forms, which apply signed overflow rules. The add rule and the subtract rule are different.
- Signed and unsigned magnitude compares, plus an equality test.
- A per-byte unsigned compare that packs eight comparison bits into the low byte of the result.

The trap is reported as a flag only. Delivering the exception is the surrounding pipeline's job.

Top module: `intarith_unit`

## Requirements
- R1: While `rst_n` is low, `res_o`, `ovf_o` and `bad_fn_o` are all zero.
- R2: The block samples `fn_i`, `opa_i` and `opb_i` on a rising clock edge. The outputs for those inputs hold from that edge until the next one.
- R3: Plain add and subtract use these codes:
  - 32-bit add 0x00 and 32-bit subtract 0x09. These use the low 32 bits of the operands, and the 32-bit result is sign-extended from bit 31 to 64 bits.
  - 64-bit add 0x20 and 64-bit subtract 0x29. These are 64-bit modular operations.
- R4: Scaled forms shift A left before the add or subtract, and bits shifted out are lost:
  - Shift by 2: codes 0x02 and 0x22 (add), 0x0B and 0x2B (subtract B from the shifted A).
  - Shift by 3: codes 0x12 and 0x32 (add), 0x1B and 0x3B (subtract).
  - Codes below 0x20 are 32-bit and follow the sign-extension rule of R3.
- R5: The trapping add codes are 0x40 (32-bit) and 0x60 (64-bit). `ovf_o` is 1 when A and B have the same sign bit and the result's sign bit differs from A's. The sign bit is bit 31 for 32-bit forms and bit 63 for 64-bit forms.
- R6: The trapping subtract codes are 0x49 (32-bit) and 0x69 (64-bit). `ovf_o` is 1 when A and B have different sign bits and the result's sign bit differs from A's.
- R7: For every function that is not one of 0x40, 0x60, 0x49 or 0x69, `ovf_o` is 0. When overflow is flagged, the wrapped result is still delivered on `res_o`.
- R8: Compare codes yield 1 or 0 in a 64-bit result:
  - 0x2D: equal.
  - 0x6D: signed less-or-equal. 0x4D: signed less-than.
  - 0x3D: unsigned less-or-equal. 0x1D: unsigned less-than.
- R9: Code 0x0F sets result bit i (i = 0..7) when byte i of A, taken as unsigned, is greater than or equal to byte i of B. All higher result bits are 0.
- R10: Any other function code sets `bad_fn_o` to 1, with `res_o` zero and `ovf_o` 0. Every recognised code sets `bad_fn_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fn_i | input | 7 | Function code |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B (register or literal, already selected) |
| res_o | output | 64 | Registered result |
| ovf_o | output | 1 | Registered overflow-trap flag |
| bad_fn_o | output | 1 | Registered illegal-function flag |

## Verification
The only state is the output register, so any fault shows up at the ports on the cycle after the inputs are sampled. A decode fault can take several forms:
- a wrong scale amount;
- a swapped operand size;
- a missing sign extension;
- an add overflow rule applied to a subtract.

Each of these corrupts the result, or raises or drops the trap flag, on the very next cycle. For that reason the bench checks every operation one cycle after it is applied. The overflow rules are stressed with operands at the sign boundaries of both the 32-bit and 64-bit forms, where a one-bit sign slip is visible.

// File: rtl/intarith_pkg.sv
package intarith_pkg;

    localparam int FN_W = 7;

    typedef enum logic [1:0] {
        OPK_NONE  = 2'd0,
        OPK_ARITH = 2'd1,
        OPK_CMP   = 2'd2,
        OPK_BYTES = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        CMP_EQ  = 3'd0,
        CMP_SLE = 3'd1,
        CMP_SLT = 3'd2,
        CMP_ULE = 3'd3,
        CMP_ULT = 3'd4
    } cmp_sel_e;

    typedef struct packed {
        op_kind_e   kind;
        logic       sub;
        logic [1:0] shamt;
        logic       quad;
        logic       trap;
        cmp_sel_e   cmp;
    } fn_ctl_t;

    // Map a function code to control fields; unknown codes give OPK_NONE.
    function automatic fn_ctl_t decode_fn(input logic [FN_W-1:0] fn);
        fn_ctl_t c;
        c = '{kind: OPK_NONE, sub: 1'b0, shamt: 2'd0, quad: 1'b0, trap: 1'b0, cmp: CMP_EQ};
        case (fn)
            7'h00: begin c.kind = OPK_ARITH; end
            7'h40: begin c.kind = OPK_ARITH; c.trap = 1'b1; end
            7'h02: begin c.kind = OPK_ARITH; c.shamt = 2'd2; end
            7'h12: begin c.kind = OPK_ARITH; c.shamt = 2'd3; end
            7'h20: begin c.kind = OPK_ARITH; c.quad = 1'b1; end
            7'h60: begin c.kind = OPK_ARITH; c.quad = 1'b1; c.trap = 1'b1; end
            7'h22: begin c.kind = OPK_ARITH; c.quad = 1'b1; c.shamt = 2'd2; end
            7'h32: begin c.kind = OPK_ARITH; c.quad = 1'b1; c.shamt = 2'd3; end
            7'h09: begin c.kind = OPK_ARITH; c.sub = 1'b1; end
            7'h49: begin c.kind = OPK_ARITH; c.sub = 1'b1; c.trap = 1'b1; end
            7'h0B: begin c.kind = OPK_ARITH; c.sub = 1'b1; c.shamt = 2'd2; end
            7'h1B: begin c.kind = OPK_ARITH; c.sub = 1'b1; c.shamt = 2'd3; end
            7'h29: begin c.kind = OPK_ARITH; c.sub = 1'b1; c.quad = 1'b1; end
            7'h69: begin c.kind = OPK_ARITH; c.sub = 1'b1; c.quad = 1'b1; c.trap = 1'b1; end
            7'h2B: begin c.kind = OPK_ARITH; c.sub = 1'b1; c.quad = 1'b1; c.shamt = 2'd2; end
            7'h3B: begin c.kind = OPK_ARITH; c.sub = 1'b1; c.quad = 1'b1; c.shamt = 2'd3; end
            7'h2D: begin c.kind = OPK_CMP; c.cmp = CMP_EQ;  end
            7'h6D: begin c.kind = OPK_CMP; c.cmp = CMP_SLE; end
            7'h4D: begin c.kind = OPK_CMP; c.cmp = CMP_SLT; end
            7'h3D: begin c.kind = OPK_CMP; c.cmp = CMP_ULE; end
            7'h1D: begin c.kind = OPK_CMP; c.cmp = CMP_ULT; end
            7'h0F: begin c.kind = OPK_BYTES; end
            default: c.kind = OPK_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/intarith_addsub.sv
module intarith_addsub #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic [1:0]        shamt_i,
    input  logic              quad_i,
    input  logic              trap_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              ovf_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] a_scaled;
    logic [DATA_W-1:0] raw;
    logic              sgn_a, sgn_b, sgn_r;
    logic              same_sign;

    always_comb begin
        a_scaled = a_i << shamt_i;
        raw      = sub_i ? (a_scaled - b_i) : (a_scaled + b_i);
        if (quad_i) begin
            sum_o = raw;
            sgn_a = a_i[DATA_W-1];
            sgn_b = b_i[DATA_W-1];
            sgn_r = raw[DATA_W-1];
        end else begin
            sum_o = {{HALF_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
            sgn_a = a_i[HALF_W-1];
            sgn_b = b_i[HALF_W-1];
            sgn_r = raw[HALF_W-1];
        end
        same_sign = (sgn_a == sgn_b);
        ovf_o     = trap_i && (sub_i ? !same_sign : same_sign) && (sgn_r != sgn_a);
    end

    // R7
    always_comb begin
        if (!trap_i) begin
            assert (ovf_o == 1'b0);
        end
    end

endmodule

// File: rtl/intarith_cmp.sv
module intarith_cmp
    import intarith_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0]        a_i,
    input  logic [DATA_W-1:0]        b_i,
    input  cmp_sel_e                 sel_i,
    output logic                     flag_o,
    output logic [DATA_W/LANE_W-1:0] lanes_o
);
    localparam int LANES = DATA_W / LANE_W;

    logic eq, slt, ult;

    always_comb begin
        eq  = (a_i == b_i);
        slt = ($signed(a_i) < $signed(b_i));
        ult = (a_i < b_i);
        case (sel_i)
            CMP_EQ:  flag_o = eq;
            CMP_SLE: flag_o = slt | eq;
            CMP_SLT: flag_o = slt;
            CMP_ULE: flag_o = ult | eq;
            CMP_ULT: flag_o = ult;
            default: flag_o = 1'b0;
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lanes_o[i] = (a_i[i*LANE_W +: LANE_W] >= b_i[i*LANE_W +: LANE_W]);
    end

endmodule

// File: rtl/intarith_unit.sv
module intarith_unit
    import intarith_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FN_W-1:0]   fn_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [DATA_W-1:0] res_o,
    output logic              ovf_o,
    output logic              bad_fn_o
);
    localparam int LANES  = DATA_W / LANE_W;
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              ovf;
        logic              bad;
    } out_t;

    fn_ctl_t           ctl;
    logic [DATA_W-1:0] arith_res;
    logic              arith_ovf;
    logic              cmp_flag;
    logic [LANES-1:0]  lane_mask;
    out_t              out_d, out_q;
    logic              armed_q;

    assign ctl = decode_fn(fn_i);

    intarith_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_i     (opa_i),
        .b_i     (opb_i),
        .sub_i   (ctl.sub),
        .shamt_i (ctl.shamt),
        .quad_i  (ctl.quad),
        .trap_i  (ctl.trap),
        .sum_o   (arith_res),
        .ovf_o   (arith_ovf)
    );

    intarith_cmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
        .a_i     (opa_i),
        .b_i     (opb_i),
        .sel_i   (ctl.cmp),
        .flag_o  (cmp_flag),
        .lanes_o (lane_mask)
    );

    always_comb begin
        out_d = '0;
        case (ctl.kind)
            OPK_ARITH: begin
                out_d.res = arith_res;
                out_d.ovf = arith_ovf;
            end
            OPK_CMP:   out_d.res = {{(DATA_W-1){1'b0}}, cmp_flag};
            OPK_BYTES: out_d.res = {{(DATA_W-LANES){1'b0}}, lane_mask};
            default:   out_d.bad = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            out_q   <= out_d;
            armed_q <= 1'b1;
        end
    end

    assign res_o    = out_q.res;
    assign ovf_o    = out_q.ovf;
    assign bad_fn_o = out_q.bad;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (res_o == '0 && !ovf_o && !bad_fn_o));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(ctl.trap)) |-> !ovf_o);

    // R8
    cmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(ctl.kind) == OPK_CMP) |-> (res_o[DATA_W-1:1] == '0));

    // R9
    byte_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(ctl.kind) == OPK_BYTES) |-> (res_o[DATA_W-1:LANES] == '0));

    // R10
    bad_fn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_fn_o |-> (res_o == '0 && !ovf_o));

    // R3
    long_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(ctl.kind) == OPK_ARITH && !$past(ctl.quad))
        |-> (res_o[DATA_W-1:HALF_W] == {HALF_W{res_o[HALF_W-1]}}));

endmodule

// File: tb/intarith_unit_test.sv
module intarith_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  fn_i = '0;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic [63:0] res_o;
    logic        ovf_o;
    logic        bad_fn_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    intarith_unit uut (
        .clk(clk), .rst_n(rst_n), .fn_i(fn_i), .opa_i(opa_i), .opb_i(opb_i),
        .res_o(res_o), .ovf_o(ovf_o), .bad_fn_o(bad_fn_o)
    );

    localparam logic [6:0] CODES [22] = '{
        7'h00, 7'h40, 7'h02, 7'h12, 7'h20, 7'h60, 7'h22, 7'h32,
        7'h09, 7'h49, 7'h0B, 7'h1B, 7'h29, 7'h69, 7'h2B, 7'h3B,
        7'h2D, 7'h6D, 7'h4D, 7'h3D, 7'h1D, 7'h0F
    };

    // expected {bad, ovf, res}
    function automatic logic [65:0] model(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r = '0;
        logic ov = 0, bad = 0;
        logic is_sub, is_q, is_t, arith;
        int sh;
        logic [31:0] r32;
        longint wide32;
        logic signed [64:0] wide64;
        arith = 1; is_sub = 0; is_q = 0; is_t = 0; sh = 0;
        case (f)
            7'h00: ; 7'h40: is_t = 1; 7'h02: sh = 2; 7'h12: sh = 3;
            7'h20: is_q = 1; 7'h60: begin is_q = 1; is_t = 1; end
            7'h22: begin is_q = 1; sh = 2; end 7'h32: begin is_q = 1; sh = 3; end
            7'h09: is_sub = 1; 7'h49: begin is_sub = 1; is_t = 1; end
            7'h0B: begin is_sub = 1; sh = 2; end 7'h1B: begin is_sub = 1; sh = 3; end
            7'h29: begin is_sub = 1; is_q = 1; end
            7'h69: begin is_sub = 1; is_q = 1; is_t = 1; end
            7'h2B: begin is_sub = 1; is_q = 1; sh = 2; end
            7'h3B: begin is_sub = 1; is_q = 1; sh = 3; end
            default: arith = 0;
        endcase
        if (arith) begin
            if (is_q) begin
                r = is_sub ? ((a << sh) - b) : ((a << sh) + b);
                wide64 = is_sub ? ($signed({a[63], a}) - $signed({b[63], b}))
                                : ($signed({a[63], a}) + $signed({b[63], b}));
                ov = is_t && (wide64[64] != wide64[63]);
            end else begin
                r32 = is_sub ? ((a[31:0] << sh) - b[31:0]) : ((a[31:0] << sh) + b[31:0]);
                r = {{32{r32[31]}}, r32};
                wide32 = is_sub ? (longint'($signed(a[31:0])) - longint'($signed(b[31:0])))
                                : (longint'($signed(a[31:0])) + longint'($signed(b[31:0])));
                ov = is_t && (wide32 != longint'($signed(r32)));
            end
        end else begin
            case (f)
                7'h2D: r = 64'(a == b);
                7'h6D: r = 64'($signed(a) <= $signed(b));
                7'h4D: r = 64'($signed(a) < $signed(b));
                7'h3D: r = 64'(a <= b);
                7'h1D: r = 64'(a < b);
                7'h0F: for (int i = 0; i < 8; i++) r[i] = (a[8*i +: 8] >= b[8*i +: 8]);
                default: bad = 1;
            endcase
        end
        return {bad, ov, r};
    endfunction

    function automatic string req_of(input logic [6:0] f);
        case (f)
            7'h00, 7'h20, 7'h09, 7'h29: return "R3";
            7'h02, 7'h12, 7'h22, 7'h32, 7'h0B, 7'h1B, 7'h2B, 7'h3B: return "R4";
            7'h40, 7'h60: return "R5";
            7'h49, 7'h69: return "R6";
            7'h2D, 7'h6D, 7'h4D, 7'h3D, 7'h1D: return "R8";
            7'h0F: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic compare(input string req, input logic [65:0] exp);
        checks++;
        if ({bad_fn_o, ovf_o, res_o} !== exp) begin
            errors++;
            $display("FAIL %s: fn=%h actual bad=%b ovf=%b res=%h expected bad=%b ovf=%b res=%h",
                     req, fn_i, bad_fn_o, ovf_o, res_o, exp[65], exp[64], exp[63:0]);
        end
    endtask

    task automatic apply(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b, input string req);
        @(negedge clk);
        fn_i = f; opa_i = a; opb_i = b;
        @(negedge clk);
        compare(req, model(f, a, b));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [6:0] f;
        logic [63:0] a, b;
        void'($urandom(32'd2024));
        fn_i = 7'h20; opa_i = 64'hFFFF; opb_i = 64'h1;
        repeat (3) @(negedge clk);
        // R1 reset holds outputs at zero
        compare("R1", 66'd0);
        rst_n = 1'b1;

        // R2 latency: before the edge old value, after the edge new value
        @(negedge clk);
        fn_i = 7'h20; opa_i = 64'd5; opb_i = 64'd7;
        @(negedge clk);
        compare("R2", {2'b00, 64'd12});
        fn_i = 7'h29; opa_i = 64'd1; opb_i = 64'd3;
        @(posedge clk); #1;
        compare("R2", {2'b00, 64'hFFFF_FFFF_FFFF_FFFE});
        @(negedge clk);

        // R3 longword sign extension and quad wrap
        apply(7'h00, 64'h0000_0000_7FFF_FFFF, 64'd1, "R3");
        apply(7'h09, 64'hFFFF_FFFF_0000_0000, 64'd1, "R3");
        apply(7'h20, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R3");
        // R4 scaled with bits lost
        apply(7'h02, 64'h4000_0001, 64'd3, "R4");
        apply(7'h3B, 64'hE000_0000_0000_0001, 64'd1, "R4");
        apply(7'h1B, 64'd10, 64'd100, "R4");
        // R5 add overflow edges
        apply(7'h40, 64'h7FFF_FFFF, 64'd1, "R5");
        apply(7'h40, 64'h8000_0000, 64'h8000_0000, "R5");
        apply(7'h60, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, "R5");
        apply(7'h60, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
        // R6 subtract overflow edges
        apply(7'h49, 64'h8000_0000, 64'd1, "R6");
        apply(7'h49, 64'h8000_0000, 64'h8000_0000, "R6");
        apply(7'h69, 64'h8000_0000_0000_0000, 64'd1, "R6");
        apply(7'h69, 64'd0, 64'h8000_0000_0000_0000, "R6");
        // R7 non-trapping forms with overflowing operands
        apply(7'h00, 64'h7FFF_FFFF, 64'd1, "R7");
        apply(7'h29, 64'h8000_0000_0000_0000, 64'd1, "R7");
        // R8 compares at sign boundary
        apply(7'h4D, 64'h8000_0000_0000_0000, 64'd0, "R8");
        apply(7'h1D, 64'h8000_0000_0000_0000, 64'd0, "R8");
        apply(7'h6D, 64'd9, 64'd9, "R8");
        apply(7'h3D, 64'd9, 64'd9, "R8");
        apply(7'h2D, 64'd9, 64'd8, "R8");
        // R9 bytewise
        apply(7'h0F, 64'h00FF_1080_0102_7F00, 64'h0100_1081_0002_8000, "R9");
        // R10 unknown codes
        apply(7'h01, 64'd3, 64'd4, "R10");
        apply(7'h7F, 64'hFFFF, 64'd1, "R10");

        for (int n = 0; n < 3000; n++) begin
            f = ($urandom % 4 != 0) ? CODES[$urandom % 22] : 7'($urandom);
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if ($urandom % 4 == 0) a[63] = ~a[62];
            if ($urandom % 4 == 0) a[31] = ~a[30];
            apply(f, a, b, req_of(f));
        end

        // R1 reset again after activity
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        compare("R1", 66'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule